// File: doc/BRIEF.md
# Oversampled Bitstream Decimator for a Comparator-Based Converter

This block is the digital half of an analog-to-digital converter whose analog half is a differential comparator and an external RC integrator. On every clock edge it registers the comparator decision. It drives that registered bit back out on a feedback pin, which closes the modulator loop through the external network. The same one-bit stream enters a cascaded integrator-comb decimator. That decimator reduces the rate by `OVERSAMPLE_RATE` and yields an unsigned code of `ADC_BITLEN` bits.

The parameter `CIC_STAGES` sets how many integrators and combs are cascaded. With `USE_FIR_COMP` set, a symmetric three-tap filter follows the decimator to lift the passband droop. Its coefficients are `-a, 1+2a, -a`, with `a = FIR_COMP_ALPHA_8/8`. The filter has no multipliers: every product is a sum of shifted copies. Each new output code comes with a one-clock valid pulse, so the sample rate is the clock rate divided by the oversampling ratio.

Top module: `sdadc_decim`

## Requirements
- R1: After every rising clock edge taken out of reset, `fb_out` equals the value `cmp_in` had at that edge.
- R2: `sample_valid` is high for exactly one clock at a time. After the first pulse following reset, consecutive pulses are exactly `OVERSAMPLE_RATE` clocks apart.
- R3: `sample_out` changes only in a cycle where `sample_valid` is high and holds its value otherwise.
- R4: Apply a bit pattern that repeats every `OVERSAMPLE_RATE` clocks and carries k ones per period. Once settled, the decimator output (compensator off) is k·R^(S-1), with R the ratio and S the stage count. This holds with the default width `ADC_BITLEN = S·log2(R)`. An all-zero input gives code 0. The integrators wrap modulo their width without disturbing this result.
- R5: A constant all-ones input, whose exact result R^S would need one more bit, gives the maximum code 2^ADC_BITLEN-1 and never wraps to 0.
- R6: With the compensator on, let x0 be the newest decimator sample and x1, x2 the two before it. Each output is floor(((8+2k)·x1 − k·(x0+x2))/8), with k = `FIR_COMP_ALPHA_8`. The result is saturated to 0 below and 2^ADC_BITLEN-1 above. It appears with a valid pulse one clock after the decimator's own valid. A settled constant input therefore passes unchanged.
- R7: While `rst` is high, `fb_out`, `sample_out` and `sample_valid` are 0. Reset clears all integrator, comb and filter history, so an all-zero input applied after a reset gives code 0 from the first sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator decision from the differential input buffer |
| fb_out | output | 1 | Registered comparator bit driven to the external integrator |
| sample_out | output | ADC_BITLEN | Unsigned decimated (and optionally compensated) sample |
| sample_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
Every cycle, the checker confirms three things: the feedback pin mirrors the previous comparator bit, the valid strobe is a single-cycle pulse at the exact decimation spacing, and the sample bus is steady between strobes. The numerical behaviour cannot be stated as a per-cycle property. This covers the settled gain for periodic patterns of chosen density, the full-scale clamp, the compensator's formula with its floor and saturation on steps, and the clearing of history by reset. The bench's scenarios show these by comparing settled codes with k·R^(S-1). It also recomputes each compensated output from the uncompensated instance's last three samples.

// File: rtl/sdadc_pkg.sv
`timescale 1ns/1ps
package sdadc_pkg;
   // Compensator taps are expressed in units of 1/2^ALPHA_SHIFT
   localparam int ALPHA_SHIFT = 3;
   localparam int ALPHA_MAX   = 1 << ALPHA_SHIFT;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sdadc_fb_reg.sv
`timescale 1ns/1ps
module sdadc_fb_reg (
   input  logic clk,
   input  logic rst,
   input  logic cmp_in,
   output logic bit_q
);
   always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= cmp_in;
   end
endmodule

// File: rtl/sdadc_cic.sv
`timescale 1ns/1ps
module sdadc_cic #(
   parameter int RATIO  = 16,
   parameter int STAGES = 2,
   parameter int OUT_W  = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_in,
   output logic [OUT_W-1:0] smp,
   output logic             smp_valid
);
   localparam int LOGR = $clog2(RATIO);
   localparam int CW   = STAGES * LOGR;   // bits of the full-scale code
   localparam int W    = CW + 1;          // register width, holds R^S exactly

   logic [W-1:0]    acc [STAGES];
   logic [W-1:0]    dly [STAGES];
   logic [W-1:0]    stage_in [STAGES+1];
   logic [LOGR-1:0] phase;
   logic            tick;
   logic [CW-1:0]   sat;
   logic [OUT_W-1:0] scaled;

   // integrators at the full clock rate, wrapping modulo 2^W
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) acc[i] <= '0;
      end else begin
         acc[0] <= acc[0] + {{(W-1){1'b0}}, bit_in};
         for (int i = 1; i < STAGES; i++) acc[i] <= acc[i] + acc[i-1];
      end
   end

   // decimation phase; ratio is a power of two so the counter wraps itself
   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase + 1'b1;
   end
   assign tick = &phase;

   // combs at the decimated rate, differential delay of one
   assign stage_in[0] = acc[STAGES-1];
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_comb
         assign stage_in[i+1] = stage_in[i] - dly[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) dly[i] <= '0;
      end else if (tick) begin
         for (int i = 0; i < STAGES; i++) dly[i] <= stage_in[i];
      end
   end

   // full scale R^S is the only value with the top bit set: clamp it
   assign sat = stage_in[STAGES][CW] ? {CW{1'b1}} : stage_in[STAGES][CW-1:0];

   generate
      if (OUT_W <= CW) begin : g_trim
         assign scaled = sat[CW-1 -: OUT_W];
      end else begin : g_pad
         assign scaled = {sat, {(OUT_W-CW){1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         smp       <= '0;
         smp_valid <= 1'b0;
      end else begin
         smp_valid <= tick;
         if (tick) smp <= scaled;
      end
   end
endmodule

// File: rtl/sdadc_comp_fir.sv
`timescale 1ns/1ps
module sdadc_comp_fir
   import sdadc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int KTAP  = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] x_in,
   input  logic          in_valid,
   output logic [DW-1:0] y_out,
   output logic          y_valid
);
   localparam int SW = DW + ALPHA_SHIFT + 3;
   localparam int CENTER = ALPHA_MAX + 2 * KTAP;
   localparam logic signed [SW-1:0] YMAX = {{(SW-DW){1'b0}}, {DW{1'b1}}};

   logic [DW-1:0]        x1, x2;
   logic signed [SW-1:0] x0s, x1s, x2s, acc, yq;
   logic [DW-1:0]        ysat;

   // constant product as a sum of shifted copies
   function automatic logic signed [SW-1:0] cmul(input logic signed [SW-1:0] v,
                                                 input int c);
      logic signed [SW-1:0] s;
      s = '0;
      for (int b = 0; b < ALPHA_SHIFT + 2; b++)
         if (c[b]) s = s + (v <<< b);
      return s;
   endfunction

   assign x0s = signed'({{(SW-DW){1'b0}}, x_in});
   assign x1s = signed'({{(SW-DW){1'b0}}, x1});
   assign x2s = signed'({{(SW-DW){1'b0}}, x2});
   assign acc = cmul(x1s, CENTER) - cmul(x0s + x2s, KTAP);
   assign yq  = acc >>> ALPHA_SHIFT;

   always_comb begin
      if (yq < 0)         ysat = '0;
      else if (yq > YMAX) ysat = '1;
      else                ysat = yq[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x1      <= '0;
         x2      <= '0;
         y_out   <= '0;
         y_valid <= 1'b0;
      end else begin
         y_valid <= in_valid;
         if (in_valid) begin
            y_out <= ysat;
            x1    <= x_in;
            x2    <= x1;
         end
      end
   end
endmodule

// File: rtl/sdadc_decim.sv
`timescale 1ns/1ps
module sdadc_decim
   import sdadc_pkg::*;
#(
   parameter int OVERSAMPLE_RATE  = 16,
   parameter int CIC_STAGES       = 2,
   parameter int ADC_BITLEN       = 8,
   parameter bit USE_FIR_COMP     = 1'b0,
   parameter int FIR_COMP_ALPHA_8 = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cmp_in,
   output logic                  fb_out,
   output logic [ADC_BITLEN-1:0] sample_out,
   output logic                  sample_valid
);
   logic                  bit_q;
   logic [ADC_BITLEN-1:0] cic_smp;
   logic                  cic_valid;

   initial begin
      param_ratio_chk: assert (is_pow2(OVERSAMPLE_RATE))
         else $error("OVERSAMPLE_RATE must be a power of two >= 2");
      param_stage_chk: assert (CIC_STAGES >= 1 && ADC_BITLEN >= 1)
         else $error("CIC_STAGES and ADC_BITLEN must be positive");
      param_alpha_chk: assert (FIR_COMP_ALPHA_8 >= 0 && FIR_COMP_ALPHA_8 <= ALPHA_MAX)
         else $error("FIR_COMP_ALPHA_8 out of range");
   end

   sdadc_fb_reg u_fb (
      .clk    (clk),
      .rst    (rst),
      .cmp_in (cmp_in),
      .bit_q  (bit_q)
   );
   assign fb_out = bit_q;

   sdadc_cic #(
      .RATIO  (OVERSAMPLE_RATE),
      .STAGES (CIC_STAGES),
      .OUT_W  (ADC_BITLEN)
   ) u_cic (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (bit_q),
      .smp       (cic_smp),
      .smp_valid (cic_valid)
   );

   generate
      if (USE_FIR_COMP) begin : g_comp
         sdadc_comp_fir #(
            .DW   (ADC_BITLEN),
            .KTAP (FIR_COMP_ALPHA_8)
         ) u_fir (
            .clk      (clk),
            .rst      (rst),
            .x_in     (cic_smp),
            .in_valid (cic_valid),
            .y_out    (sample_out),
            .y_valid  (sample_valid)
         );
      end else begin : g_bypass
         assign sample_out   = cic_smp;
         assign sample_valid = cic_valid;
      end
   endgenerate
endmodule

// File: rtl/sdadc_decim_chk.sv
`timescale 1ns/1ps
module sdadc_decim_chk #(
   parameter int R = 16,
   parameter int B = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         cmp_in,
   input logic         fb_out,
   input logic [B-1:0] sample_out,
   input logic         sample_valid
);
   logic        live;
   logic        seen;
   logic [31:0] gap;

   always_ff @(posedge clk) begin
      if (rst) begin
         live <= 1'b0;
         seen <= 1'b0;
         gap  <= '0;
      end else begin
         live <= 1'b1;
         if (sample_valid) begin
            seen <= 1'b1;
            gap  <= '0;
         end else begin
            gap <= gap + 1;
         end
      end
   end

   // R1
   fb_mirror_chk: assert property (@(posedge clk) disable iff (rst)
      live |-> (fb_out == $past(cmp_in)));

   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      sample_valid |=> !sample_valid);

   // R2
   valid_period_chk: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && seen) |-> (gap == R - 1));

   // R2
   valid_late_chk: assert property (@(posedge clk) disable iff (rst)
      seen |-> (gap < R));

   // R3
   sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (live && !sample_valid) |-> $stable(sample_out));
endmodule

bind sdadc_decim sdadc_decim_chk #(
   .R (OVERSAMPLE_RATE),
   .B (ADC_BITLEN)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cmp_in       (cmp_in),
   .fb_out       (fb_out),
   .sample_out   (sample_out),
   .sample_valid (sample_valid)
);

// File: tb/sdadc_decim_tb.sv
`timescale 1ns/1ps
module sdadc_decim_tb;
   localparam int R = 16;
   localparam int S = 2;
   localparam int B = 8;
   localparam int K = 2;
   localparam int MAXC = (1 << B) - 1;
   localparam int NSAMP = 7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmp_in = 1'b0;
   logic fb_a, fb_b;
   logic [B-1:0] smp_a, smp_b;
   logic vld_a, vld_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sdadc_decim #(.OVERSAMPLE_RATE(R), .CIC_STAGES(S), .ADC_BITLEN(B),
                 .USE_FIR_COMP(1'b0), .FIR_COMP_ALPHA_8(K)) u_dut (
      .clk(clk), .rst(rst), .cmp_in(cmp_in), .fb_out(fb_a),
      .sample_out(smp_a), .sample_valid(vld_a));

   sdadc_decim #(.OVERSAMPLE_RATE(R), .CIC_STAGES(S), .ADC_BITLEN(B),
                 .USE_FIR_COMP(1'b1), .FIR_COMP_ALPHA_8(K)) u_dut_fir (
      .clk(clk), .rst(rst), .cmp_in(cmp_in), .fb_out(fb_b),
      .sample_out(smp_b), .sample_valid(vld_b));

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic int exp_steady(input int k);
      int v;
      v = k * (R ** (S - 1));
      return (v > MAXC) ? MAXC : v;
   endfunction

   function automatic int exp_fir(input int x0, input int x1, input int x2);
      int a;
      a = ((8 + 2 * K) * x1 - K * (x0 + x2)) >>> 3;
      if (a < 0) a = 0;
      if (a > MAXC) a = MAXC;
      return a;
   endfunction

   // monitor: valid spacing and compensator formula
   int h0 = 0, h1 = 0, h2 = 0;
   int gap_cnt = 0;
   bit have_prev = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         h0 = 0; h1 = 0; h2 = 0;
         have_prev = 1'b0;
         gap_cnt = 0;
      end else if (!done) begin
         gap_cnt++;
         if (vld_a) begin
            if (have_prev) check("R2 valid spacing", gap_cnt, R);
            have_prev = 1'b1;
            gap_cnt = 0;
            h2 = h1; h1 = h0; h0 = int'(smp_a);
         end
         if (vld_b) check("R6 compensated sample", int'(smp_b), exp_fir(h0, h1, h2));
      end
   end

   int phase = 0;
   bit fb_ok = 1'b0;
   logic prev_drive = 1'b0;

   task automatic run_seg(input logic [R-1:0] pat, output int sa, output int sb);
      int ca = 0, cb = 0;
      sa = 0; sb = 0;
      while (cb < NSAMP) begin
         @(negedge clk);
         if (fb_ok) begin
            check("R1 feedback mirror", int'(fb_a), int'(prev_drive));
            check("R1 feedback mirror fir", int'(fb_b), int'(prev_drive));
         end
         if (vld_a) begin ca++; sa = int'(smp_a); end
         if (vld_b) begin cb++; sb = int'(smp_b); end
         cmp_in = pat[phase];
         prev_drive = pat[phase];
         fb_ok = 1'b1;
         phase = (phase + 1) % R;
      end
   endtask

   task automatic steady(input string req, input logic [R-1:0] pat);
      int sa, sb, e;
      run_seg(pat, sa, sb);
      e = exp_steady($countones(pat));
      check(req, sa, e);
      check({req, " (compensated) R6"}, sb, e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      cmp_in = 1'b1;
      fb_ok = 1'b0;
      repeat (4) @(negedge clk);
      // R7 outputs held at zero during reset
      check("R7 fb in reset", int'(fb_a), 0);
      check("R7 sample in reset", int'(smp_a), 0);
      check("R7 valid in reset", int'(vld_a), 0);
      check("R7 fir sample in reset", int'(smp_b), 0);
      check("R7 fir valid in reset", int'(vld_b), 0);
      rst = 1'b0;
      cmp_in = 1'b0;
      phase = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int first;
      void'($urandom(32'h5EED_0017));
      do_reset();

      // R4 directed densities
      steady("R4 zero input", '0);
      steady("R4 single one", 16'h0001);
      steady("R4 half density", 16'hAAAA);
      steady("R4 fifteen ones", 16'hFFFE);
      // R5 full scale clamp, then step down to exercise R6 saturation
      steady("R5 full scale clamp", '1);
      steady("R4 step to zero", '0);
      steady("R5 full scale again", '1);
      steady("R4 quarter density", 16'h1111);

      // R4 random patterns, long enough for the integrators to wrap
      for (int i = 0; i < 24; i++) begin
         logic [R-1:0] p;
         p = R'($urandom());
         steady("R4 random pattern", p);
      end

      // R7 reset clears history: all-ones then reset then zero input
      steady("R5 before reset", '1);
      do_reset();
      first = -1;
      while (first < 0) begin
         @(negedge clk);
         if (vld_a) first = int'(smp_a);
      end
      check("R7 first sample after reset", first, 0);
      steady("R7 zero after reset", '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule